// File: doc/BRIEF.md
# PRBS Bit Error Rate Receiver

This block checks a serial test stream against a 2^15-1 pseudo-random sequence (feedback x^15 + x^14 + 1). While it is hunting, the incoming bits seed a local pattern generator. When enough consecutive bits agree with the prediction, the generator runs on its own. From then on, each received bit is compared with the generated bit. The block finds out whether the stream arrives true or complemented. It drops lock when errors cluster, and it flags long runs of ones or zeros on the line.

Two 32-bit counters track the received bits and the detected errors. A measurement period ends in one of two ways: the bit count reaches a programmed length, or a snapshot command arrives. At that point both counts are copied into result registers, the running counters restart, and an end-of-period flag is raised. The result registers stay frozen while that flag is pending. Reading the error result clears the flag.

A status word combines live conditions with sticky copies that clear on a status read. Software reads the status word and the two results through a small address-selected read port with a read strobe.

Top module: `prbs_rx_tester`

## Requirements
- R1: After reset the status word reads 0x021: sticky out-of-lock (bit 5) and live out-of-lock (bit 0) are set. Both result registers read 0.
- R2: `in_ready` is always 1, so the stream is never back-pressured. A bit is taken only in a cycle with `in_valid` high. Cycles with `in_valid` low change neither the pattern state, the run detectors nor the bit counter.
- R3: While hunting, a bit is scored as true-polarity if it equals the XOR of the bits received 14 and 15 places earlier, and as complemented otherwise. The score counts only when those last 15 bits contain both a 0 and a 1. After 32 consecutive scored bits of the same polarity, status bit 0 clears on the next cycle.
- R4: Status bit 8 is 1 when lock was gained on the complemented sequence and 0 when lock was gained on the true sequence. It keeps its value until the next lock.
- R5: While locked, an error is a taken bit that differs from the generated bit. When the errors among the last 64 taken bits reach 6, lock is lost and status bit 0 returns to 1.
- R6: Live all-ones (bit 2) and live all-zeros (bit 1) are each 1 once the last 32 taken bits were all 1, or all 0. Each clears in the cycle after the first taken bit of the other value.
- R7: Sticky bits 7 (all-ones), 6 (all-zeros), 5 (out-of-lock) and 3 (bit error) are set when their condition is present in any cycle. A status read (`rd_en` with address 0) clears them. If the condition is present in the same cycle as the read, the bit stays set.
- R8: The bit counter counts taken bits, and the error counter counts errors while locked. When the bit count, including the current bit, reaches `cfg_interval` (0 disables this), the counts including the current bit become the results. Both counters then restart from 0.
- R9: `cmd_snap` ends the period in the same way, whatever the count is. Either ending sets status bit 4 on the next cycle.
- R10: While bit 4 is set, the results do not change. A read at address 2 clears bit 4. If a period ends in the same cycle as that read, new results are stored and bit 4 stays set.
- R11: `rd_data` shows the status word (zero-extended) at address 0, the bit result at 1, the error result at 2, and 0 at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Serial bit valid |
| in_ready | output | 1 | Always 1 |
| in_bit | input | 1 | Received data bit |
| cfg_interval | input | 32 | Measurement length in taken bits, 0 = no expiry |
| cmd_snap | input | 1 | Force end of measurement period |
| rd_en | input | 1 | Read strobe (side effects on status and error result) |
| rd_addr | input | 2 | Register select |
| rd_data | output | 32 | Selected register value, combinational |

## Verification
On every cycle the assertions check these rules: ready stays high, the two live run flags are never both set, an error pulse is followed by the sticky error bit, a snapshot command raises the period flag, and the results hold while that flag is pending without an error-result read. They also check that lock is gained only on a taken bit and that the polarity does not change while locked. Only the bench scenarios can show the rest. That covers the exact 32-bit acquisition point and the exclusion of constant histories, and the 6-in-64 loss threshold. It also covers the exact snapshot counts at interval expiry, clearing on read racing a new event, and the complemented-stream lock. A behavioural model compares the selected register with the design on every clock.

// File: rtl/prbs_rx_pkg.sv
package prbs_rx_pkg;

  // Status word, MSB first: bit 8 down to bit 0
  typedef struct packed {
    logic inv;    // 8
    logic s_one;  // 7
    logic s_zero; // 6
    logic s_oos;  // 5
    logic eop;    // 4
    logic s_err;  // 3
    logic one;    // 2
    logic zero;   // 1
    logic oos;    // 0
  } status_t;

  localparam int STAT_W = $bits(status_t);

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_BITS   = 2'd1;
  localparam logic [1:0] ADDR_ERRS   = 2'd2;

  // Pattern polynomial x^15 + x^14 + 1
  localparam int PAT_LEN  = 15;
  localparam int TAP_OLD  = 14;
  localparam int TAP_NEXT = 13;

endpackage

// File: rtl/prbs_rx_sync.sv
module prbs_rx_sync
  import prbs_rx_pkg::*;
#(
  parameter int SYNC_LEN = 32,
  parameter int WIN      = 64,
  parameter int LOS_THR  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic bit_in,
  output logic in_sync,
  output logic inv,
  output logic err_pulse
);
  localparam int CW = $clog2(SYNC_LEN + 1);
  localparam int WW = $clog2(WIN + 1);

  logic [PAT_LEN-1:0] hist;
  logic [CW-1:0]      hunt_cnt, hunt_nxt;
  logic               hunt_pol, pol_nxt;
  logic [WIN-1:0]     win;
  logic [WW-1:0]      win_cnt, win_nxt;
  logic               pred, exp_bit, mixed, mism, err_now;

  assign pred    = hist[TAP_OLD] ^ hist[TAP_NEXT];
  assign exp_bit = pred ^ inv;
  assign mixed   = (|hist) && !(&hist);
  assign mism    = bit_in ^ pred;
  assign err_now = in_sync && (bit_in != exp_bit);
  assign err_pulse = valid && err_now;
  assign win_nxt = win_cnt + WW'(err_now) - WW'(win[WIN-1]);

  always_comb begin
    hunt_nxt = hunt_cnt;
    pol_nxt  = hunt_pol;
    if (!mixed) begin
      hunt_nxt = '0;
    end else if (hunt_cnt != '0 && mism == hunt_pol) begin
      hunt_nxt = hunt_cnt + CW'(1);
    end else begin
      hunt_nxt = CW'(1);
      pol_nxt  = mism;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist     <= '0;
      hunt_cnt <= '0;
      hunt_pol <= 1'b0;
      win      <= '0;
      win_cnt  <= '0;
      in_sync  <= 1'b0;
      inv      <= 1'b0;
    end else if (valid) begin
      if (in_sync) begin
        hist    <= {hist[PAT_LEN-2:0], exp_bit};
        win     <= {win[WIN-2:0], err_now};
        win_cnt <= win_nxt;
        if (win_nxt >= WW'(LOS_THR)) begin
          in_sync  <= 1'b0;
          hunt_cnt <= '0;
        end
      end else begin
        hist     <= {hist[PAT_LEN-2:0], bit_in};
        hunt_pol <= pol_nxt;
        if (hunt_nxt == CW'(SYNC_LEN)) begin
          in_sync  <= 1'b1;
          inv      <= pol_nxt;
          hunt_cnt <= '0;
          win      <= '0;
          win_cnt  <= '0;
        end else begin
          hunt_cnt <= hunt_nxt;
        end
      end
    end
  end

endmodule

// File: rtl/prbs_rx_run.sv
module prbs_rx_run #(
  parameter int RUN_LEN = 32,
  parameter bit MATCH   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic bit_in,
  output logic live
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] run;

  assign live = (run == RW'(RUN_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0;
    end else if (valid) begin
      if (bit_in == MATCH) begin
        if (!live) run <= run + RW'(1);
      end else begin
        run <= '0;
      end
    end
  end

endmodule

// File: rtl/prbs_rx_meas.sv
module prbs_rx_meas #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             err,
  input  logic             snap_cmd,
  input  logic             clr,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] res_bits,
  output logic [CNT_W-1:0] res_errs,
  output logic             pending
);
  logic [CNT_W-1:0] bit_cnt, err_cnt, bit_nxt, err_nxt;
  logic             expire, period_end, may_store;

  assign bit_nxt    = bit_cnt + CNT_W'(valid);
  assign err_nxt    = err_cnt + CNT_W'(err);
  assign expire     = (interval != '0) && (bit_nxt >= interval);
  assign period_end = expire || snap_cmd;
  assign may_store  = !pending || clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      err_cnt  <= '0;
      res_bits <= '0;
      res_errs <= '0;
      pending  <= 1'b0;
    end else begin
      pending <= (pending && !clr) || period_end;
      if (period_end) begin
        bit_cnt <= '0;
        err_cnt <= '0;
        if (may_store) begin
          res_bits <= bit_nxt;
          res_errs <= err_nxt;
        end
      end else begin
        bit_cnt <= bit_nxt;
        err_cnt <= err_nxt;
      end
    end
  end

endmodule

// File: rtl/prbs_rx_tester.sv
module prbs_rx_tester
  import prbs_rx_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SYNC_LEN = 32,
  parameter int RUN_LEN  = 32,
  parameter int LOS_WIN  = 64,
  parameter int LOS_THR  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  input  logic [CNT_W-1:0] cfg_interval,
  input  logic             cmd_snap,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  logic             take, in_sync, inv_pol, err_pulse;
  logic [1:0]       live_run;  // [0] zeros, [1] ones
  logic             s_one, s_zero, s_oos, s_err, eop;
  logic             stat_rd, err_rd;
  logic [CNT_W-1:0] res_bits, res_errs;
  status_t          stat_word;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;
  assign stat_rd  = rd_en && (rd_addr == ADDR_STATUS);
  assign err_rd   = rd_en && (rd_addr == ADDR_ERRS);

  prbs_rx_sync #(
    .SYNC_LEN(SYNC_LEN), .WIN(LOS_WIN), .LOS_THR(LOS_THR)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .valid(take), .bit_in(in_bit),
    .in_sync(in_sync), .inv(inv_pol), .err_pulse(err_pulse)
  );

  for (genvar g = 0; g < 2; g++) begin : g_run
    prbs_rx_run #(.RUN_LEN(RUN_LEN), .MATCH(g == 1)) u_run (
      .clk(clk), .rst_n(rst_n), .valid(take), .bit_in(in_bit),
      .live(live_run[g])
    );
  end

  prbs_rx_meas #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .valid(take), .err(err_pulse),
    .snap_cmd(cmd_snap), .clr(err_rd), .interval(cfg_interval),
    .res_bits(res_bits), .res_errs(res_errs), .pending(eop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_one  <= 1'b0;
      s_zero <= 1'b0;
      s_oos  <= 1'b1;
      s_err  <= 1'b0;
    end else begin
      s_one  <= (s_one  && !stat_rd) || live_run[1];
      s_zero <= (s_zero && !stat_rd) || live_run[0];
      s_oos  <= (s_oos  && !stat_rd) || !in_sync;
      s_err  <= (s_err  && !stat_rd) || err_pulse;
    end
  end

  always_comb begin
    stat_word.inv    = inv_pol;
    stat_word.s_one  = s_one;
    stat_word.s_zero = s_zero;
    stat_word.s_oos  = s_oos;
    stat_word.eop    = eop;
    stat_word.s_err  = s_err;
    stat_word.one    = live_run[1];
    stat_word.zero   = live_run[0];
    stat_word.oos    = !in_sync;
  end

  always_comb begin
    case (rd_addr)
      ADDR_STATUS: rd_data = {{(CNT_W-STAT_W){1'b0}}, stat_word};
      ADDR_BITS:   rd_data = res_bits;
      ADDR_ERRS:   rd_data = res_errs;
      default:     rd_data = '0;
    endcase
  end

endmodule

// File: rtl/prbs_rx_tester_chk.sv
module prbs_rx_tester_chk
  import prbs_rx_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             cmd_snap,
  input logic             err_rd,
  input logic             err_pulse,
  input status_t          stat,
  input logic [CNT_W-1:0] res_bits,
  input logic [CNT_W-1:0] res_errs
);
  // R2
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  // R6
  run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat.one && stat.zero));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> stat.s_err);

  // R9
  snap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_snap |=> stat.eop);

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.eop && !err_rd) |=> ($stable(res_bits) && $stable(res_errs)));

  // R3
  lock_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat.oos) |-> $past(in_valid));

  // R4
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat.oos && !$past(stat.oos)) |-> $stable(stat.inv));

endmodule

bind prbs_rx_tester prbs_rx_tester_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cmd_snap(cmd_snap), .err_rd(err_rd), .err_pulse(err_pulse),
  .stat(stat_word), .res_bits(res_bits), .res_errs(res_errs)
);

// File: tb/prbs_rx_tester_tb.sv
module prbs_rx_tester_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_bit = 1'b0, cmd_snap = 1'b0, rd_en = 1'b0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] cfg_interval = 32'd0;
  logic        in_ready;
  logic [31:0] rd_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [14:0] src = 15'h1ACE;

  // reference model state
  bit hq[$];
  bit wq[$];
  bit m_sync, m_inv, m_pol, la1, la0, loos, lbe, eoi;
  int m_hunt, ones, zeros;
  int unsigned bitc, errc, rb, re;

  prbs_rx_tester u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .cfg_interval(cfg_interval), .cmd_snap(cmd_snap),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned mstat();
    return {23'd0, m_inv, la1, la0, loos, eoi, lbe, (ones >= 32), (zeros >= 32), !m_sync};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hq.delete(); wq.delete();
      for (int i = 0; i < 15; i++) hq.push_back(1'b0);
      m_sync = 0; m_inv = 0; m_pol = 0; m_hunt = 0;
      la1 = 0; la0 = 0; loos = 1; lbe = 0; eoi = 0;
      ones = 0; zeros = 0; bitc = 0; errc = 0; rb = 0; re = 0;
    end else begin
      bit pred, expb, errp, mix, mism, sread, eread, endv;
      int cnt1;
      int unsigned bn, en;
      pred  = hq[0] ^ hq[1];
      expb  = pred ^ m_inv;
      errp  = in_valid && m_sync && (in_bit != expb);
      sread = rd_en && rd_addr == 2'd0;
      eread = rd_en && rd_addr == 2'd2;
      la1  = (la1 && !sread) || (ones >= 32);
      la0  = (la0 && !sread) || (zeros >= 32);
      loos = (loos && !sread) || !m_sync;
      lbe  = (lbe && !sread) || errp;
      bn = bitc + (in_valid ? 1 : 0);
      en = errc + (errp ? 1 : 0);
      endv = ((cfg_interval != 0) && (bn >= cfg_interval)) || cmd_snap;
      if (endv) begin
        if (!eoi || eread) begin rb = bn; re = en; end
        bitc = 0; errc = 0;
      end else begin
        bitc = bn; errc = en;
      end
      eoi = (eoi && !eread) || endv;
      if (in_valid) begin
        if (in_bit) begin ones = (ones < 32) ? ones + 1 : 32; zeros = 0; end
        else begin zeros = (zeros < 32) ? zeros + 1 : 32; ones = 0; end
        if (m_sync) begin
          wq.push_back(errp);
          if (wq.size() > 64) void'(wq.pop_front());
          cnt1 = 0;
          foreach (wq[i]) cnt1 += wq[i];
          if (cnt1 >= 6) begin m_sync = 0; m_hunt = 0; end
          hq.push_back(expb);
        end else begin
          cnt1 = 0;
          foreach (hq[i]) cnt1 += hq[i];
          mix  = (cnt1 > 0) && (cnt1 < 15);
          mism = in_bit ^ pred;
          if (!mix) m_hunt = 0;
          else if (m_hunt != 0 && mism == m_pol) m_hunt++;
          else begin m_hunt = 1; m_pol = mism; end
          if (m_hunt == 32) begin
            m_sync = 1; m_inv = m_pol; m_hunt = 0; wq.delete();
          end
          hq.push_back(in_bit);
        end
        void'(hq.pop_front());
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int unsigned e;
      chk("R2 ready", in_ready, 1);
      case (rd_addr)
        2'd0: begin
          e = mstat();
          chk("R3 lock", rd_data & 32'h001, e & 32'h001);
          chk("R4 polarity", rd_data & 32'h100, e & 32'h100);
          chk("R6 live runs", rd_data & 32'h006, e & 32'h006);
          chk("R7 sticky", rd_data & 32'h0E8, e & 32'h0E8);
          chk("R9 period flag", rd_data & 32'h010, e & 32'h010);
        end
        2'd1: chk("R8 bit result", rd_data, rb);
        2'd2: chk("R8 error result", rd_data, re);
        default: chk("R11 empty address", rd_data, 0);
      endcase
    end
  end

  task automatic step(bit v, bit b, bit cmd = 0, bit ren = 0, int addr = -1);
    @(posedge clk); #1;
    cyc++;
    in_valid = v; in_bit = b; cmd_snap = cmd; rd_en = ren;
    rd_addr = (addr < 0) ? 2'(cyc % 4) : 2'(addr);
  endtask

  task automatic look(int addr, output int unsigned val);
    @(posedge clk); #1;
    in_valid = 0; cmd_snap = 0; rd_en = 0; rd_addr = 2'(addr);
    @(negedge clk);
    val = rd_data;
  endtask

  function automatic bit nxt_src();
    bit o;
    o = src[14] ^ src[13];
    src = {src[13:0], o};
    return o;
  endfunction

  task automatic pattern(int n, bit invert, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 2)) step(0, 1'b1);
      step(1, nxt_src() ^ invert);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned v;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    look(0, v); chk("R1 status reset", v, 32'h021);
    look(1, v); chk("R1 bit result reset", v, 0);
    look(2, v); chk("R1 error result reset", v, 0);

    for (int i = 0; i < 40; i++) step(1, 0);
    look(0, v);
    chk("R6 all zeros live", (v >> 1) & 1, 1);
    chk("R3 no lock on constant", v & 1, 1);
    for (int i = 0; i < 40; i++) step(1, 1);
    look(0, v);
    chk("R6 all ones live", (v >> 1) & 3, 2);
    chk("R7 sticky zeros", (v >> 6) & 1, 1);
    step(0, 0, 0, 1, 0);
    look(0, v);
    chk("R7 zeros cleared by read", (v >> 6) & 1, 0);
    chk("R7 ones kept, still live", (v >> 7) & 1, 1);
    chk("R7 oos kept, still live", (v >> 5) & 1, 1);

    pattern(300, 0, 1);
    look(0, v);
    chk("R3 locked on true pattern", v & 1, 0);
    chk("R4 true polarity", (v >> 8) & 1, 0);
    step(0, 0, 0, 1, 0);
    look(0, v);
    chk("R7 oos cleared once locked", (v >> 5) & 1, 0);

    step(1, nxt_src(), 1);
    look(0, v); chk("R9 snapshot sets flag", (v >> 4) & 1, 1);
    look(2, v); chk("R8 no errors counted", v, 0);
    step(0, 0, 0, 1, 2);
    for (int i = 0; i < 60; i++) step(1, nxt_src() ^ (i % 20 == 5));
    step(0, 0, 1);
    look(2, v); chk("R8 three errors", v, 3);
    look(1, v); chk("R8 sixty bits", v, 60);
    for (int i = 0; i < 10; i++) step(1, nxt_src() ^ (i == 2));
    step(0, 0, 1);
    look(2, v); chk("R10 frozen error result", v, 3);
    look(1, v); chk("R10 frozen bit result", v, 60);
    step(0, 0, 0, 1, 2);
    look(0, v); chk("R10 flag cleared by error read", (v >> 4) & 1, 0);

    for (int i = 0; i < 10; i++) step(0, 1);
    step(0, 0, 1);
    look(1, v); chk("R2 invalid cycles not counted", v, 0);
    step(0, 0, 0, 1, 2);

    cfg_interval = 100;
    for (int i = 0; i < 100; i++) step(1, nxt_src());
    look(0, v); chk("R8 interval expiry flag", (v >> 4) & 1, 1);
    look(1, v); chk("R8 interval bit count", v, 100);
    cfg_interval = 0;
    step(0, 0, 1, 1, 2);
    look(0, v); chk("R10 end with read keeps flag", (v >> 4) & 1, 1);

    step(0, 0, 0, 1, 0);
    step(1, nxt_src() ^ 1'b1, 0, 1, 0);
    look(0, v); chk("R7 event during read kept", (v >> 3) & 1, 1);

    for (int i = 0; i < 20; i++) step(1, nxt_src() ^ (i % 3 == 0));
    look(0, v);
    chk("R5 lock lost", v & 1, 1);

    pattern(300, 1, 0);
    look(0, v);
    chk("R3 locked on complement", v & 1, 0);
    chk("R4 complemented polarity", (v >> 8) & 1, 1);
    look(3, v); chk("R11 address three", v, 0);

    repeat (5) step(0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule